// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single clause-22 management transactions on an MDIO bus. A client pulses a start strobe together with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit word. The block then generates MDC from the system clock and serialises the whole frame: preamble, start and opcode bits, both addresses, turnaround and data. It drives MDIO through a separate value/enable pair and receives the pad value on its own input.

On a read the master releases MDIO from the first turnaround bit onward. It passes the returned line through a two-flop synchroniser and checks that a PHY pulls the turnaround bit low. It then collects sixteen data bits. If no PHY answers, the line stays high through the turnaround. In that case the master clocks a run of recovery cycles with the line released and reports an error instead of data. Completion is a single-cycle done pulse. The result is held until the next accepted request.

Top module: `mdio_master`

## Requirements
- R1: After reset and whenever no transaction is running, mdc_o is 1, mdio_oe_o is 0 and busy_o is 0.
- R2: Each MDC low phase and each MDC high phase lasts HALF_CYC system clocks (default 4). While mdio_oe_o is 1, mdio_out_o changes only while MDC is low.
- R3: A frame starts with 32 MDC rising edges at which the line is 1, followed by two edges carrying 0 then 1.
- R4: The next two edges carry the opcode: 1,0 for a read (rd_i=1) and 0,1 for a write (rd_i=0). Then come the 5 PHY address bits and then the 5 register address bits, each field most significant bit first.
- R5: A write continues with turnaround 1,0 and the 16 data bits MSB first. It then releases MDIO for one more MDC cycle. done_o follows after 65 MDC rising edges in total, with err_o=0 and rdata_o=0.
- R6: A read releases MDIO from the first turnaround bit. mdio_in_i is sampled through a two-flop synchroniser as seen at each MDC rising edge. When the turnaround sample is 0, the 16 following bits form rdata_o MSB first. One trailing MDC cycle follows. done_o comes after 64 rising edges, with err_o=0.
- R7: When the turnaround sample of a read is 1, the master gives 32 further MDC cycles with MDIO released, 79 rising edges in total. It then completes with err_o=1 and rdata_o=0.
- R8: busy_o is 1 from the cycle after an accepted start until done_o. A start while busy is ignored: the running frame is unchanged, nothing is written, and no extra done_o appears.
- R9: done_o is high for exactly one clock, with busy_o already 0. err_o and rdata_o hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, accepted only when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read result, zero for writes and errors |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No PHY drove the turnaround low |
| busy_o | output | 1 | Transaction in progress |
| mdc_o | output | 1 | Management clock |
| mdio_out_o | output | 1 | Value driven on MDIO |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_in_i | input | 1 | MDIO pad value |

## Verification
The hardest condition to reach is the missing-PHY path. It needs a read in which nothing pulls the released line low during turnaround, while data samples are still being scheduled in the synchroniser pipeline. The bench models a pulled-up bus and a single responding PHY at one address. Reads aimed at other addresses then reach the recovery run naturally, and a valid read right afterwards shows that the error state does not leak. A request strobed halfway through a read covers the ignored-start case, and a later read-back shows that the ignored request wrote nothing.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_TX, ST_RX} mdio_st_e;
  typedef enum logic [1:0] {SMP_NONE, SMP_TA, SMP_DATA} smp_kind_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic tick_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_o <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b1;
    end else if (tick_o) begin
      cnt_q <= '0;
      mdc_o <= ~mdc_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_rest_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> mdc_o);
endmodule

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYC    = 4,
  parameter int PRE_BITS    = 32,
  parameter int RECOV_BITS  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rd_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        done_o,
  output logic        err_o,
  output logic        busy_o,
  output logic        mdc_o,
  output logic        mdio_out_o,
  output logic        mdio_oe_o,
  input  logic        mdio_in_i
);
  localparam int HDR_BITS = PRE_BITS + 14;           // preamble..register address
  localparam int WR_BITS  = HDR_BITS + 18;           // + turnaround + data
  localparam int RD_LAST  = 17;                      // TA, 16 data, trailing
  localparam int MAXB     = (WR_BITS > RECOV_BITS) ? WR_BITS : RECOV_BITS + 1;
  localparam int BCW      = $clog2(MAXB + 1);
  localparam int SMP_LAT  = SYNC_STAGES + 1;

  mdio_st_e           st_q;
  logic               rd_q, err_q, done_q;
  logic [WR_BITS-1:0] tx_sr;
  logic [BCW-1:0]     bit_q, tx_end, rx_end;
  logic [15:0]        rdata_q;
  smp_kind_e          pipe_q [SMP_LAT];
  smp_kind_e          push_kind;
  logic               mdc, tick, run, mdio_s;
  logic               hi_end, lo_end, finish, accept;

  mdio_mdc_gen #(.HALF_CYC(HALF_CYC)) u_mdc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .mdc_o (mdc),
    .tick_o(tick)
  );

  mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mdio_in_i),
    .q_o   (mdio_s)
  );

  always_comb begin
    hi_end = tick && mdc;
    lo_end = tick && !mdc;
    tx_end = rd_q ? BCW'(HDR_BITS - 1) : BCW'(WR_BITS - 1);
    if (!rd_q)      rx_end = '0;
    else if (err_q) rx_end = BCW'(RECOV_BITS);
    else            rx_end = BCW'(RD_LAST);
    finish = (st_q == ST_RX) && hi_end && (bit_q == rx_end);
    run    = (st_q != ST_IDLE) && !finish;
    accept = start_i && (st_q == ST_IDLE);
    // tag the rising edge about to happen with what it samples
    push_kind = SMP_NONE;
    if ((st_q == ST_RX) && rd_q && lo_end) begin
      if (bit_q == '0)                  push_kind = SMP_TA;
      else if (bit_q <= BCW'(16))       push_kind = SMP_DATA;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rd_q   <= 1'b0;
      tx_sr  <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q  <= ST_LEAD;
          rd_q  <= rd_i;
          bit_q <= '0;
          tx_sr <= {{PRE_BITS{1'b1}}, 2'b01, (rd_i ? 2'b10 : 2'b01),
                    phy_addr_i, reg_addr_i, 2'b10, wdata_i};
        end
        ST_LEAD: if (tick) st_q <= ST_TX;
        ST_TX: if (hi_end) begin
          tx_sr <= tx_sr << 1;
          if (bit_q == tx_end) begin
            st_q  <= ST_RX;
            bit_q <= '0;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        ST_RX: if (hi_end) begin
          if (finish) st_q  <= ST_IDLE;
          else        bit_q <= bit_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // sample pipeline covers the synchroniser latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SMP_LAT; i++) pipe_q[i] <= SMP_NONE;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      pipe_q[0] <= push_kind;
      for (int i = 1; i < SMP_LAT; i++) pipe_q[i] <= pipe_q[i-1];
      if (accept) begin
        err_q   <= 1'b0;
        rdata_q <= '0;
      end else if (pipe_q[SMP_LAT-1] == SMP_TA) begin
        if (mdio_s) err_q <= 1'b1;
      end else if (pipe_q[SMP_LAT-1] == SMP_DATA && !err_q) begin
        rdata_q <= {rdata_q[14:0], mdio_s};
      end
    end
  end

  assign mdc_o      = mdc;
  assign mdio_oe_o  = (st_q == ST_TX);
  assign mdio_out_o = tx_sr[WR_BITS-1];
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign rdata_o    = rdata_q;

  p_idle_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mdio_oe_o && mdc_o));
  p_drive_low_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o) && mdio_oe_o && $past(mdio_oe_o)) |-> $stable(mdio_out_o));
  p_err_nodata_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == 16'h0000));
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(rdata_o) && $stable(err_o)));
endmodule

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam int HALF = 4;
  localparam logic [4:0] PHY_ADDR = 5'h0B;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rd = 1'b0;
  logic [4:0] pa = '0, ra = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic done, err, busy, mdc, mout, moe;
  logic drv_en = 1'b0, drv_bit = 1'b0;
  wire  mdio_line = moe ? mout : (drv_en ? drv_bit : 1'b1);

  always #2.5 clk = ~clk;

  mdio_master #(.HALF_CYC(HALF)) i_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_i(rd),
    .phy_addr_i(pa), .reg_addr_i(ra), .wdata_i(wd),
    .rdata_o(rdata), .done_o(done), .err_o(err), .busy_o(busy),
    .mdc_o(mdc), .mdio_out_o(mout), .mdio_oe_o(moe), .mdio_in_i(mdio_line)
  );

  typedef struct { logic err; logic [15:0] data; int rises; } exp_t;
  exp_t sbq[$];
  exp_t mon_e;

  int n_chk = 0, n_err = 0, rises = 0, resp = 0;
  logic [63:0] hist = '0;
  logic [15:0] resp_word = '0;
  logic [15:0] phy_mem [32];
  logic [15:0] ref_mem [32];
  logic        e_rd = 1'b0, cur_wr = 1'b0;
  logic [4:0]  e_pa = '0, e_ra = '0, cur_reg = '0;
  logic [15:0] e_wd = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // PHY model: captures the frame at MDC rising edges, answers one address
  always @(posedge mdc) if (busy) begin
    hist = {hist[62:0], mdio_line};
    rises++;
    if (rises == 46) begin
      check(hist[45:12] == {{32{1'b1}}, 2'b01}, "R3 preamble and start",
            32'(hist[13:12]), 32'h1);
      check(hist[11:0] == {(e_rd ? 2'b10 : 2'b01), e_pa, e_ra}, "R4 opcode and addresses",
            32'(hist[11:0]), 32'({(e_rd ? 2'b10 : 2'b01), e_pa, e_ra}));
      cur_reg = hist[4:0];
      cur_wr  = (hist[11:10] == 2'b01) && (hist[9:5] == PHY_ADDR);
      if (hist[11:10] == 2'b10 && hist[9:5] == PHY_ADDR) begin
        resp = 17;
        resp_word = phy_mem[hist[4:0]];
      end else resp = 0;
    end
    if (rises == 64 && cur_wr) begin
      check(hist[17:16] == 2'b10, "R5 write turnaround", 32'(hist[17:16]), 32'h2);
      check(hist[15:0] == e_wd, "R5 write data", 32'(hist[15:0]), 32'(e_wd));
      phy_mem[cur_reg] = hist[15:0];
    end
  end

  always @(negedge mdc) if (busy) begin
    if (resp > 0) begin
      drv_en  = 1'b1;
      drv_bit = (resp == 17) ? 1'b0 : resp_word[resp-1];
      resp--;
    end else drv_en = 1'b0;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && done) begin
    if (sbq.size() == 0) check(1'b0, "R8 unexpected done", 32'h1, 32'h0);
    else begin
      mon_e = sbq.pop_front();
      check(err == mon_e.err, "R7 err flag", 32'(err), 32'(mon_e.err));
      check(rdata == mon_e.data, "R6 read data", 32'(rdata), 32'(mon_e.data));
      check(rises == mon_e.rises, "R5/R6/R7 MDC edge count", 32'(rises), 32'(mon_e.rises));
      check(!busy, "R9 busy low with done", 32'(busy), 32'h0);
    end
  end

  task automatic do_frame(input logic r, input logic [4:0] p, input logic [4:0] g, input logic [15:0] w);
    exp_t e;
    if (r) begin
      if (p == PHY_ADDR) e = '{1'b0, ref_mem[g], 64};
      else               e = '{1'b1, 16'h0, 79};
    end else begin
      if (p == PHY_ADDR) ref_mem[g] = w;
      e = '{1'b0, 16'h0, 65};
    end
    sbq.push_back(e);
    e_rd = r; e_pa = p; e_ra = g; e_wd = w;
    rises = 0; resp = 0; hist = '0; cur_wr = 1'b0;
    @(negedge clk);
    start = 1'b1; rd = r; pa = p; ra = g; wd = w;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 busy after accept", 32'(busy), 32'h1);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(!done, "R9 done single pulse", 32'(done), 32'h0);
    check(mdc && !moe && !busy, "R1 idle after frame", 32'({mdc, moe, busy}), 32'h4);
  endtask

  task automatic measure_phase();
    int n;
    @(negedge mdc);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (mdc == 1'b0);
    check(n == HALF, "R2 MDC low phase", 32'(n), 32'(HALF));
    n = 0;
    do begin @(posedge clk); #1; n++; end while (mdc == 1'b1);
    check(n == HALF, "R2 MDC high phase", 32'(n), 32'(HALF));
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      phy_mem[i] = 16'(16'h1357 + i * 16'h0421);
      ref_mem[i] = phy_mem[i];
    end
    repeat (4) @(negedge clk);
    check(mdc && !moe && !busy && !done, "R1 reset state",
          32'({mdc, moe, busy, done}), 32'h8);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    fork
      do_frame(1'b0, PHY_ADDR, 5'd3, 16'hA5C3);
      measure_phase();
    join
    do_frame(1'b1, PHY_ADDR, 5'd3, 16'h0);
    do_frame(1'b0, PHY_ADDR, 5'd31, 16'h8001);
    do_frame(1'b1, PHY_ADDR, 5'd31, 16'h0);
    do_frame(1'b1, PHY_ADDR, 5'd0, 16'h0);
    do_frame(1'b0, PHY_ADDR, 5'd0, 16'hFFFF);
    do_frame(1'b1, PHY_ADDR, 5'd0, 16'h0);
    do_frame(1'b0, PHY_ADDR, 5'd16, 16'h0000);
    do_frame(1'b1, PHY_ADDR, 5'd16, 16'h0);
    // R7: no PHY at these addresses, line stays pulled up
    do_frame(1'b1, 5'h02, 5'd3, 16'h0);
    check(err && rdata == 16'h0, "R7 error result held", 32'({err, rdata}), 32'h10000);
    do_frame(1'b1, 5'h1F, 5'd0, 16'h0);
    do_frame(1'b1, PHY_ADDR, 5'd3, 16'h0);
    check(!err, "R9 err cleared by new frame", 32'(err), 32'h0);

    // R8: start during a read must be ignored
    fork
      do_frame(1'b1, PHY_ADDR, 5'd3, 16'h0);
      begin
        repeat (100) @(negedge clk);
        start = 1'b1; rd = 1'b0; pa = PHY_ADDR; ra = 5'd3; wd = 16'h0000;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy held across ignored start", 32'(busy), 32'h1);
      end
    join
    repeat (20) @(negedge clk);
    do_frame(1'b1, PHY_ADDR, 5'd3, 16'h0);
    do_frame(1'b0, 5'h05, 5'd7, 16'h1234);

    repeat (20) @(negedge clk);
    check(sbq.size() == 0, "R8 all expected completions seen", 32'(sbq.size()), 32'h0);
    summary();
    $finish;
  end
endmodule